// File: doc/BRIEF.md
# Weighted-Random SJF / Round-Robin Batch Arbiter

The arbiter sits between per-source batch queues and the per-bank command queues of a memory controller. Each source presents the head request of its oldest complete batch, a flag saying that batch is ready, and its current number of outstanding memory requests. Whenever the arbiter is free and at least one source is ready, it picks one source. It uses one of two rules for that choice. The shortest-job rule picks the ready source with the fewest outstanding requests. The rotating rule picks the next ready source after the last one it served.

The rule used for each decision is chosen at random. An 8-bit probability value, set by software, is compared against a free-running 8-bit LFSR. The shortest-job rule wins when the LFSR value is below the setting. A setting of zero therefore always yields the rotating rule, and a setting of all ones always yields the shortest-job rule. A low setting favours bandwidth-heavy sources such as a graphics engine. A high setting favours latency-sensitive CPU sources.

Once a source is granted, its whole batch is streamed out, one request per cycle, in the order the source presents it. Each request is pushed into the queue named by its bank field, and only when that queue can accept it. The arbiter decides again only after the last request of the batch has left.

Top module: `bat_arb`

## Requirements
- R1: After reset, no bank push, no source pop and no output valid are issued until a source becomes ready.
- R2: While no source is ready, no grant is made and no bank queue receives a push.
- R3: In shortest-job mode, the granted source is the ready source with the smallest outstanding count. Ties go to the lowest source index.
- R4: In rotating mode, the granted source is the first ready source at or after the rotation pointer, wrapping from the last index to 0. The pointer moves to one past the granted source only on rotating-mode grants. After reset the pointer is 0.
- R5: A probability setting of 0x00 always selects rotating mode and 0xFF always selects shortest-job mode. `out_sjf_o` is 1 for a batch granted in shortest-job mode and 0 for a batch granted in rotating mode.
- R6: For an intermediate setting p, shortest-job mode is chosen when the LFSR value is below p. With p = 0x80, roughly half of the decisions (30% to 70% over 200 decisions) use shortest-job mode.
- R7: A granted batch is drained completely, in source order, before any other source is granted. `out_src_o` stays constant through the batch, and the batch ends with the request whose last flag is set.
- R8: Each request is pushed into exactly one bank queue. That queue's one-hot bit equals `1 << bank field`. No push occurs while the addressed bank is not ready, and the request is then held.
- R9: The granted source is popped in exactly the cycles in which its request is pushed, and only then.
- R10: Sources that are not granted are never popped. A source becoming ready during another batch has no effect on that batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sjf_prob_i | input | 8 | Shortest-job probability as a fraction of 256; 0xFF forces shortest-job mode |
| src_rdy_i | input | NUM_SRC | Source has a complete batch ready at its head |
| src_last_i | input | NUM_SRC | Head request is the last of its batch |
| src_cnt_i | input | NUM_SRC x CNT_W | Outstanding request count per source |
| src_bank_i | input | NUM_SRC x BANK_W | Bank field of each head request |
| src_data_i | input | NUM_SRC x DATA_W | Payload of each head request |
| src_pop_o | output | NUM_SRC | Head request of the source consumed |
| bank_ready_i | input | NUM_BANKS | Bank queue can accept a request |
| bank_push_o | output | NUM_BANKS | One-hot push into a bank queue |
| out_valid_o | output | 1 | A request of the granted batch is presented |
| out_data_o | output | DATA_W | Payload of the presented request |
| out_bank_o | output | BANK_W | Bank field of the presented request |
| out_src_o | output | SRC_W | Source of the current batch |
| out_last_o | output | 1 | Presented request closes its batch |
| out_sjf_o | output | 1 | Current batch was granted in shortest-job mode |

## Verification
The assertions rely on a few input assumptions. A granted source keeps its ready flag asserted until the last request of its batch has been popped. Each head request stays stable until it is popped. Every bank field is below NUM_BANKS. Software changes the probability setting only while no batch is in flight. The bench's source model follows these assumptions. It holds a source ready exactly while the batch it loaded still has requests. It advances a head only in the cycle after a pop is seen. It derives every bank field modulo the bank count. Each scenario alters the probability setting and the outstanding counts only after the arbiter has gone idle.

// File: rtl/bat_arb_pkg.sv
package bat_arb_pkg;
  localparam int PROB_W = 8;

  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_DRAIN = 1'b1
  } arb_state_e;

  // maximal-length x^8+x^6+x^5+x^4+1; the all-zero state is unreachable
  function automatic logic [PROB_W-1:0] lfsr_next(input logic [PROB_W-1:0] s);
    return {s[PROB_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/bat_lfsr.sv
module bat_lfsr
  import bat_arb_pkg::*;
#(
  parameter logic [PROB_W-1:0] SEED = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PROB_W-1:0] state_o
);
  logic [PROB_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/bat_sjf_pick.sv
module bat_sjf_pick #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            rdy_i,
  input  logic [NUM_SRC-1:0][CNT_W-1:0] cnt_i,
  output logic [SRC_W-1:0]              idx_o
);
  logic             found;
  logic [CNT_W-1:0] best_cnt;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    best_cnt = '1;
    idx_o    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rdy_i[i] && (!found || cnt_i[i] < best_cnt)) begin
        found    = 1'b1;
        best_cnt = cnt_i[i];
        idx_o    = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/bat_rr_pick.sv
module bat_rr_pick #(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] rdy_i,
  input  logic [SRC_W-1:0]   ptr_i,
  output logic [SRC_W-1:0]   idx_o
);
  logic found;
  int   pos;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    pos   = 0;
    for (int k = 0; k < NUM_SRC; k++) begin
      pos = (int'(ptr_i) + k) % NUM_SRC;
      if (!found && rdy_i[pos]) begin
        found = 1'b1;
        idx_o = SRC_W'(pos);
      end
    end
  end
endmodule

// File: rtl/bat_arb.sv
module bat_arb
  import bat_arb_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 16,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [PROB_W-1:0]                sjf_prob_i,
  input  logic [NUM_SRC-1:0]               src_rdy_i,
  input  logic [NUM_SRC-1:0]               src_last_i,
  input  logic [NUM_SRC-1:0][CNT_W-1:0]    src_cnt_i,
  input  logic [NUM_SRC-1:0][BANK_W-1:0]   src_bank_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]   src_data_i,
  output logic [NUM_SRC-1:0]               src_pop_o,
  input  logic [NUM_BANKS-1:0]             bank_ready_i,
  output logic [NUM_BANKS-1:0]             bank_push_o,
  output logic                             out_valid_o,
  output logic [DATA_W-1:0]                out_data_o,
  output logic [BANK_W-1:0]                out_bank_o,
  output logic [SRC_W-1:0]                 out_src_o,
  output logic                             out_last_o,
  output logic                             out_sjf_o
);
  arb_state_e        state_q;
  logic [SRC_W-1:0]  sel_q, rr_ptr_q;
  logic              sjf_q;
  logic [PROB_W-1:0] lfsr;
  logic [SRC_W-1:0]  sjf_idx, rr_idx, win_idx;
  logic              use_sjf, grant, fire;

  bat_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(lfsr)
  );

  bat_sjf_pick #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_sjf (
    .rdy_i(src_rdy_i),
    .cnt_i(src_cnt_i),
    .idx_o(sjf_idx)
  );

  bat_rr_pick #(.NUM_SRC(NUM_SRC)) u_rr (
    .rdy_i(src_rdy_i),
    .ptr_i(rr_ptr_q),
    .idx_o(rr_idx)
  );

  assign use_sjf = (sjf_prob_i == '1) || (lfsr < sjf_prob_i);
  assign win_idx = use_sjf ? sjf_idx : rr_idx;
  assign grant   = (state_q == ARB_IDLE) && (|src_rdy_i);

  assign out_valid_o = (state_q == ARB_DRAIN) && src_rdy_i[sel_q];
  assign out_data_o  = src_data_i[sel_q];
  assign out_bank_o  = src_bank_i[sel_q];
  assign out_last_o  = src_last_i[sel_q];
  assign out_src_o   = sel_q;
  assign out_sjf_o   = sjf_q;
  assign fire        = out_valid_o && bank_ready_i[out_bank_o];

  always_comb begin
    bank_push_o = '0;
    src_pop_o   = '0;
    if (fire) begin
      bank_push_o[out_bank_o] = 1'b1;
      src_pop_o[sel_q]        = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ARB_IDLE;
      sel_q    <= '0;
      sjf_q    <= 1'b0;
      rr_ptr_q <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (grant) begin
            state_q <= ARB_DRAIN;
            sel_q   <= win_idx;
            sjf_q   <= use_sjf;
            if (!use_sjf)
              rr_ptr_q <= (win_idx == SRC_W'(NUM_SRC - 1)) ? '0 : win_idx + 1'b1;
          end
        end
        ARB_DRAIN: begin
          if (fire && out_last_o) state_q <= ARB_IDLE;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bat_arb_chk.sv
module bat_arb_chk #(
  parameter int NUM_SRC   = 4,
  parameter int NUM_BANKS = 4,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           sjf_prob_i,
  input logic [NUM_SRC-1:0]   src_rdy_i,
  input logic [NUM_SRC-1:0]   src_pop_o,
  input logic [NUM_BANKS-1:0] bank_ready_i,
  input logic [NUM_BANKS-1:0] bank_push_o,
  input logic                 out_valid_o,
  input logic [BANK_W-1:0]    out_bank_o,
  input logic [SRC_W-1:0]     out_src_o,
  input logic                 out_last_o,
  input logic                 out_sjf_o
);
  p_push_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_push_o));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !bank_ready_i[out_bank_o] |-> bank_push_o == '0);

  p_pop_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_pop_o) == $countones(bank_push_o));

  p_pop_granted_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |src_pop_o |-> src_pop_o[out_src_o]);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|src_rdy_i) |-> bank_push_o == '0);

  p_hold_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !(|bank_push_o && out_last_o) |=> $stable(out_src_o));

  p_prob_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) && $past(sjf_prob_i) == 8'h00 |-> !out_sjf_o);

  p_prob_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) && $past(sjf_prob_i) == 8'hFF |-> out_sjf_o);
endmodule

bind bat_arb bat_arb_chk #(.NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sjf_prob_i  (sjf_prob_i),
  .src_rdy_i   (src_rdy_i),
  .src_pop_o   (src_pop_o),
  .bank_ready_i(bank_ready_i),
  .bank_push_o (bank_push_o),
  .out_valid_o (out_valid_o),
  .out_bank_o  (out_bank_o),
  .out_src_o   (out_src_o),
  .out_last_o  (out_last_o),
  .out_sjf_o   (out_sjf_o)
);

// File: tb/bat_arb_tb_top.sv
module bat_arb_tb_top;
  localparam int NS = 4;
  localparam int NB = 4;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int LOGN = 1024;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [7:0]           sjf_prob_i = 8'h00;
  logic [NS-1:0]        src_rdy_i = '0;
  logic [NS-1:0]        src_last_i = '0;
  logic [NS-1:0][CW-1:0] src_cnt_i = '0;
  logic [NS-1:0][1:0]   src_bank_i = '0;
  logic [NS-1:0][DW-1:0] src_data_i = '0;
  logic [NS-1:0]        src_pop_o;
  logic [NB-1:0]        bank_ready_i = '1;
  logic [NB-1:0]        bank_push_o;
  logic                 out_valid_o;
  logic [DW-1:0]        out_data_o;
  logic [1:0]           out_bank_o;
  logic [1:0]           out_src_o;
  logic                 out_last_o;
  logic                 out_sjf_o;

  int checks = 0;
  int errors = 0;

  int blen [NS];
  int pend [NS];
  int seq  [NS];
  logic [NS-1:0] fired = '0;

  int log_n = 0;
  int log_src  [LOGN];
  int log_last [LOGN];
  int log_sjf  [LOGN];

  always #4 clk_i = ~clk_i;

  bat_arb #(.NUM_SRC(NS), .NUM_BANKS(NB), .CNT_W(CW), .DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sjf_prob_i(sjf_prob_i),
    .src_rdy_i(src_rdy_i), .src_last_i(src_last_i), .src_cnt_i(src_cnt_i),
    .src_bank_i(src_bank_i), .src_data_i(src_data_i), .src_pop_o(src_pop_o),
    .bank_ready_i(bank_ready_i), .bank_push_o(bank_push_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_bank_o(out_bank_o),
    .out_src_o(out_src_o), .out_last_o(out_last_o), .out_sjf_o(out_sjf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int head_bank(input int s);
    return (s + seq[s]) % NB;
  endfunction

  // source model: advances a head one step after the edge that consumed it
  initial begin
    for (int s = 0; s < NS; s++) begin blen[s] = 0; pend[s] = 0; seq[s] = 0; end
    forever begin
      @(posedge clk_i);
      #1;
      for (int s = 0; s < NS; s++) begin
        if (fired[s]) begin seq[s]++; blen[s]--; end
        if (blen[s] == 0 && pend[s] > 0) begin blen[s] = pend[s]; pend[s] = 0; end
        src_rdy_i[s]  = blen[s] > 0;
        src_last_i[s] = blen[s] == 1;
        src_bank_i[s] = 2'(head_bank(s));
        src_data_i[s] = DW'((s << 12) | (seq[s] & 12'hFFF));
      end
      fired = '0;
    end
  end

  // monitor away from the active edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && |bank_push_o) begin
        int s;
        s = int'(out_src_o);
        chk(bank_push_o == NB'(1 << head_bank(s)), "R8 bank one-hot", int'(bank_push_o), 1 << head_bank(s));
        chk(src_pop_o == NS'(1 << s), "R9/R10 pop of granted source", int'(src_pop_o), 1 << s);
        chk(out_data_o == DW'((s << 12) | (seq[s] & 12'hFFF)), "R7 in-order data", int'(out_data_o), (s << 12) | seq[s]);
        fired = src_pop_o;
        if (log_n < LOGN) begin
          log_src[log_n]  = s;
          log_last[log_n] = int'(out_last_o);
          log_sjf[log_n]  = int'(out_sjf_o);
          log_n++;
        end
      end else if (rst_ni && |src_pop_o) begin
        chk(1'b0, "R9 pop without push", int'(src_pop_o), 0);
      end
    end
  end

  task automatic wait_idle();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      @(negedge clk_i);
      busy = out_valid_o;
      for (int s = 0; s < NS; s++) if (blen[s] != 0 || pend[s] != 0) busy = 1'b1;
    end
    repeat (2) @(negedge clk_i);
  endtask

  // checks batch sequence and per-batch source constancy from log index first
  task automatic check_order(input int first, input int n, input int o0, input int o1,
                             input int o2, input int o3, input string req);
    int exp [4];
    int got;
    int cur;
    exp[0] = o0; exp[1] = o1; exp[2] = o2; exp[3] = o3;
    got = 0;
    cur = (first < log_n) ? log_src[first] : -1;
    for (int i = first; i < log_n; i++) begin
      if (log_src[i] != cur) chk(1'b0, "R7 batch interleaved", log_src[i], cur);
      if (log_last[i] == 1) begin
        if (got < n) chk(log_src[i] == exp[got], req, log_src[i], exp[got]);
        got++;
        if (i + 1 < log_n) cur = log_src[i + 1];
      end
    end
    chk(got == n, {req, " batch count"}, got, n);
  endtask

  task automatic check_mode(input int first, input int val, input string req);
    int bad;
    bad = 0;
    for (int i = first; i < log_n; i++) if (log_sjf[i] != val) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(bank_push_o == '0, "R1 no push after reset", int'(bank_push_o), 0);
    chk(src_pop_o == '0, "R1 no pop after reset", int'(src_pop_o), 0);
    chk(out_valid_o == 1'b0, "R1 no valid after reset", int'(out_valid_o), 0);
  endtask

  task automatic t_idle();
    int n0;
    n0 = log_n;
    repeat (12) @(negedge clk_i);
    chk(log_n == n0, "R2 no push without ready source", log_n - n0, 0);
    chk(out_valid_o == 1'b0, "R2 no grant without ready source", int'(out_valid_o), 0);
  endtask

  task automatic t_sjf();
    int n0;
    sjf_prob_i = 8'hFF;
    src_cnt_i[0] = 8'd5; src_cnt_i[1] = 8'd2; src_cnt_i[2] = 8'd2; src_cnt_i[3] = 8'd7;
    n0 = log_n;
    for (int s = 0; s < NS; s++) pend[s] = 2;
    wait_idle();
    check_order(n0, 4, 1, 2, 0, 3, "R3 fewest outstanding, lowest index on tie");
    check_mode(n0, 1, "R5 setting 0xFF forces shortest-job");
  endtask

  task automatic t_rr();
    int n0;
    sjf_prob_i = 8'h00;
    src_cnt_i[0] = 8'd9; src_cnt_i[1] = 8'd1; src_cnt_i[2] = 8'd4; src_cnt_i[3] = 8'd2;
    n0 = log_n;
    for (int s = 0; s < NS; s++) pend[s] = 1;
    wait_idle();
    check_order(n0, 4, 0, 1, 2, 3, "R4 rotation from pointer 0");
    check_mode(n0, 0, "R5 setting 0x00 forces rotating");
    n0 = log_n;
    pend[1] = 1; pend[3] = 1;
    wait_idle();
    check_order(n0, 2, 1, 3, 0, 0, "R4 rotation skips idle sources");
    n0 = log_n;
    pend[1] = 1;
    wait_idle();
    check_order(n0, 1, 1, 0, 0, 0, "R4 wrap to source 1");
    // shortest-job grant must not move the pointer (now 2)
    sjf_prob_i = 8'hFF;
    n0 = log_n;
    pend[3] = 1;
    wait_idle();
    check_mode(n0, 1, "R5 shortest-job grant flagged");
    sjf_prob_i = 8'h00;
    n0 = log_n;
    pend[1] = 1; pend[2] = 1;
    wait_idle();
    check_order(n0, 2, 2, 1, 0, 0, "R4 pointer untouched by shortest-job grant");
  endtask

  task automatic t_drain();
    int n0;
    // pointer is 2 here: source 3 first, then source 0
    sjf_prob_i = 8'h00;
    n0 = log_n;
    pend[0] = 5; pend[3] = 3;
    wait_idle();
    check_order(n0, 2, 3, 0, 0, 0, "R7 whole batch before next grant");
    chk(log_n - n0 == 8, "R10 each request pushed once", log_n - n0, 8);
  endtask

  task automatic t_stall();
    int n0, b;
    b = (2 + seq[2]) % NB;
    bank_ready_i = '1;
    bank_ready_i[b] = 1'b0;
    n0 = log_n;
    pend[2] = 3;
    repeat (10) @(negedge clk_i);
    chk(log_n == n0, "R8 no push to a busy bank", log_n - n0, 0);
    chk(out_valid_o == 1'b1, "R8 request held while bank busy", int'(out_valid_o), 1);
    chk(src_pop_o == '0, "R9 no pop while stalled", int'(src_pop_o), 0);
    bank_ready_i = '1;
    wait_idle();
    chk(log_n - n0 == 3, "R9 batch drains after release", log_n - n0, 3);
  endtask

  task automatic t_prob();
    int n0, nsjf, total;
    sjf_prob_i = 8'h80;
    src_cnt_i[0] = 8'd1; src_cnt_i[1] = 8'd9;
    n0 = log_n;
    for (int r = 0; r < 100; r++) begin
      pend[0] = 1; pend[1] = 1;
      wait_idle();
    end
    nsjf = 0;
    total = log_n - n0;
    for (int i = n0; i < log_n; i++) nsjf += log_sjf[i];
    chk(total == 200, "R6 decision count", total, 200);
    chk(nsjf >= 60 && nsjf <= 140, "R6 mixed policy near one half", nsjf, 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_idle();
    t_sjf();
    t_rr();
    t_drain();
    t_stall();
    t_prob();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule